// File: doc/BRIEF.md
# Queue Pointer Controller

This block keeps a read pointer and a write pointer for each of a set of hardware queues. A host reaches it over a simple register bus (address, write data, write enable, read enable, read data). Producers and consumers never write a pointer value directly. They post small increments to the pointer they own, and they read status words to learn where the other side stands.

Each queue has its own window of registers. A queue's capacity is a power of two chosen through a per-queue size register, and both pointers wrap modulo that capacity. The block tracks how many entries are in flight. When a write advance would overfill the queue, or a read advance would pass the data actually present, it raises a sticky flag. The host can read both flags and clear them.

Top module: `qptr_ctrl`

## Requirements
- R1: After reset every queue reads back read pointer 0, write pointer 0, both flags 0 and size code 8 (256 entries).
- R2: Queue q is mapped at byte address 0x80000 + q*0x800, with q taken from address bits 18:11 and address bit 19 set. Queues at or above NUM_Q (default 8) and addresses with bit 19 clear are unmapped: writes to them change nothing and reads from them return 0.
- R3: Writing to window offset 0x00 advances the read pointer, and writing to offset 0x04 advances the write pointer, by bits 5:0 of the write data. Higher data bits are ignored, and an increment of zero leaves the pointer unchanged.
- R4: Reading offset 0x08 returns the read pointer in bits 17:0, the overflow flag in bit 31 and the underflow flag in bit 30. Reading offset 0x0C returns the write pointer in bits 17:0. All other bits of both words read 0.
- R5: Both pointers advance modulo 2^size, where size is the queue's size code.
- R6: Offset 0x10 holds the size code in bits 4:0 and reads back the stored code. A written code above 18 is stored as 18. Writing this register sets that queue's pointers and in-flight count to zero.
- R7: A write advance that takes the in-flight count above 2^size sets the overflow flag. The write pointer still advances, and the count saturates at 2^size.
- R8: A read advance larger than the in-flight count sets the underflow flag. The read pointer still advances, and the count becomes zero.
- R9: Both flags are sticky. A write to offset 0x14 with bit 0 set clears both of them. A write there with bit 0 clear has no effect.
- R10: Read data appears in the cycle after the read enable. It is 0 in any cycle not preceded by a read. Offsets 0x00, 0x04, 0x14 and undefined offsets read 0.
- R11: An operation on one queue leaves every other queue's pointers, flags and size unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one access per cycle |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions check the following on every cycle:
- pointers stay inside the current capacity;
- a zero increment holds the pointer;
- a size write zeroes the pointers;
- the flags stay set until a clear;
- overflow only rises on a write advance;
- idle or unmapped reads return zero.

Only the bench scenarios can show the arithmetic values:
- where a pointer lands after a wrap;
- the exact boundary where overflow does and does not trigger;
- the saturated in-flight count that later governs underflow;
- the clamping of size codes;
- the layout of the status words;
- that an operation on one queue leaves the other queues untouched.

// File: rtl/qptr_pkg.sv
// Package: shared constants and the register selector type for the queue
// pointer controller. Assumes a 20-bit byte address and a 32-bit data bus.
package qptr_pkg;

    localparam int ADDR_W    = 20;
    localparam int DATA_W    = 32;
    localparam int WIN_BITS  = 11;   // 0x800-byte window per queue
    localparam int QNUM_BITS = 8;    // up to 256 queues
    localparam int REGION_BIT = 19;  // queue area starts at 0x80000

    localparam logic [WIN_BITS-1:0] OFF_ADD_RD  = 11'h000;
    localparam logic [WIN_BITS-1:0] OFF_ADD_WR  = 11'h004;
    localparam logic [WIN_BITS-1:0] OFF_STAT_RD = 11'h008;
    localparam logic [WIN_BITS-1:0] OFF_STAT_WR = 11'h00C;
    localparam logic [WIN_BITS-1:0] OFF_SIZE    = 11'h010;
    localparam logic [WIN_BITS-1:0] OFF_CLR     = 11'h014;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ADD_RD,
        SEL_ADD_WR,
        SEL_STAT_RD,
        SEL_STAT_WR,
        SEL_SIZE,
        SEL_CLR
    } qreg_e;

endpackage

// File: rtl/qptr_decode.sv
// Module: address decoder. Splits a bus address into queue number and
// register selector, and flags whether the queue exists.
// Assumes: exact offset match, so unaligned offsets decode to SEL_NONE.
module qptr_decode
    import qptr_pkg::*;
#(
    parameter int NUM_Q  = 8,
    parameter int QSEL_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [QSEL_W-1:0] qsel,
    output qreg_e             rsel
);

    logic [QNUM_BITS-1:0] qnum;
    logic [WIN_BITS-1:0]  off;

    assign qnum = addr[WIN_BITS +: QNUM_BITS];
    assign off  = addr[WIN_BITS-1:0];
    assign qsel = qnum[QSEL_W-1:0];

    // Queue exists when the region bit is set and the number is in range.
    always_comb begin
        hit = addr[REGION_BIT] && ({1'b0, qnum} < (QNUM_BITS+1)'(NUM_Q));
    end

    // Map the in-window offset to a register selector.
    always_comb begin
        case (off)
            OFF_ADD_RD:  rsel = SEL_ADD_RD;
            OFF_ADD_WR:  rsel = SEL_ADD_WR;
            OFF_STAT_RD: rsel = SEL_STAT_RD;
            OFF_STAT_WR: rsel = SEL_STAT_WR;
            OFF_SIZE:    rsel = SEL_SIZE;
            OFF_CLR:     rsel = SEL_CLR;
            default:     rsel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/qptr_slot.sv
// Module: state of one queue. Holds the read and write pointers, the size
// code, the in-flight count and the two sticky flags.
// Assumes: at most one of the write strobes is active in a cycle.
module qptr_slot #(
    parameter int PTR_W   = 18,
    parameter int INC_W   = 6,
    parameter int SZ_W    = 5,
    parameter int DEF_LOG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_rd,
    input  logic             add_wr,
    input  logic             size_wr,
    input  logic             clr_wr,
    input  logic [INC_W-1:0] inc,
    input  logic [SZ_W-1:0]  size_in,
    input  logic             clr_bit,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [SZ_W-1:0]  size_log,
    output logic             ovf,
    output logic             udf
);

    localparam int FILL_W = PTR_W + 1;

    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] cap;
    logic [FILL_W-1:0] inc_f;
    logic [FILL_W-1:0] fill_sum;
    logic [PTR_W-1:0]  inc_p;
    logic [PTR_W-1:0]  mask;
    logic [SZ_W-1:0]   size_clamped;

    // Derive capacity, wrap mask and widened increments from the size code.
    always_comb begin
        mask         = ~({PTR_W{1'b1}} << size_log);
        cap          = {{PTR_W{1'b0}}, 1'b1} << size_log;
        inc_f        = FILL_W'(inc);
        inc_p        = PTR_W'(inc);
        fill_sum     = fill_q + inc_f;
        size_clamped = (size_in > SZ_W'(PTR_W)) ? SZ_W'(PTR_W) : size_in;
    end

    // Apply the single bus operation that targets this queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            fill_q   <= '0;
            size_log <= SZ_W'(DEF_LOG);
            ovf      <= 1'b0;
            udf      <= 1'b0;
        end else if (size_wr) begin
            size_log <= size_clamped;
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            fill_q   <= '0;
        end else if (add_wr) begin
            wr_ptr <= (wr_ptr + inc_p) & mask;
            if (fill_sum > cap) begin
                ovf    <= 1'b1;
                fill_q <= cap;
            end else begin
                fill_q <= fill_sum;
            end
        end else if (add_rd) begin
            rd_ptr <= (rd_ptr + inc_p) & mask;
            if (inc_f > fill_q) begin
                udf    <= 1'b1;
                fill_q <= '0;
            end else begin
                fill_q <= fill_q - inc_f;
            end
        end else if (clr_wr && clr_bit) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_ptr & ~mask) == '0) && ((wr_ptr & ~mask) == '0)); // R5
    AST_ZERO_INC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (add_wr && inc == '0) |=> $stable(wr_ptr)); // R3
    AST_SIZE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        size_wr |=> (rd_ptr == '0 && wr_ptr == '0)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(clr_wr && clr_bit) && !size_wr) |=> ovf); // R9
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (udf && !(clr_wr && clr_bit) && !size_wr) |=> udf); // R9
    AST_OVF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(add_wr)); // R7
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= cap); // R7

endmodule

// File: rtl/qptr_rdmux.sv
// Module: read data selector. Forms the word for the addressed register.
// Write-only, undefined and unmapped registers produce zero.
// Assumes: PTR_W is at most 30, so the flags fit in bits 31:30.
module qptr_rdmux
    import qptr_pkg::*;
#(
    parameter int NUM_Q  = 8,
    parameter int QSEL_W = 3,
    parameter int PTR_W  = 18,
    parameter int SZ_W   = 5
) (
    input  logic                        hit,
    input  logic [QSEL_W-1:0]           qsel,
    input  qreg_e                       rsel,
    input  logic [NUM_Q-1:0][PTR_W-1:0] rd_ptrs,
    input  logic [NUM_Q-1:0][PTR_W-1:0] wr_ptrs,
    input  logic [NUM_Q-1:0][SZ_W-1:0]  sizes,
    input  logic [NUM_Q-1:0]            ovfs,
    input  logic [NUM_Q-1:0]            udfs,
    output logic [DATA_W-1:0]           word
);

    localparam int PAD_W = DATA_W - 2 - PTR_W;

    // Select and format the register word for the addressed queue.
    always_comb begin
        word = '0;
        if (hit) begin
            case (rsel)
                SEL_STAT_RD: word = {ovfs[qsel], udfs[qsel], {PAD_W{1'b0}}, rd_ptrs[qsel]};
                SEL_STAT_WR: word = DATA_W'(wr_ptrs[qsel]);
                SEL_SIZE:    word = DATA_W'(sizes[qsel]);
                default:     word = '0;
            endcase
        end
    end

endmodule

// File: rtl/qptr_ctrl.sv
// Module: top of the queue pointer controller. Decodes bus accesses,
// steers write strobes to one queue slot and registers read data.
// Assumes: the host issues at most one write per cycle; a read in the same
// cycle as a write sees the state from before that write.
module qptr_ctrl
    import qptr_pkg::*;
#(
    parameter int NUM_Q   = 8,
    parameter int PTR_W   = 18,
    parameter int INC_W   = 6,
    parameter int DEF_LOG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [19:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata
);

    localparam int QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int SZ_W   = $clog2(PTR_W + 1);

    logic              hit;
    logic [QSEL_W-1:0] qsel;
    qreg_e             rsel;
    logic [DATA_W-1:0] rd_word;
    logic              wdata_unused;

    logic [NUM_Q-1:0][PTR_W-1:0] rd_ptrs;
    logic [NUM_Q-1:0][PTR_W-1:0] wr_ptrs;
    logic [NUM_Q-1:0][SZ_W-1:0]  sizes;
    logic [NUM_Q-1:0]            ovfs;
    logic [NUM_Q-1:0]            udfs;

    assign wdata_unused = ^bus_wdata[DATA_W-1:INC_W];

    qptr_decode #(.NUM_Q(NUM_Q), .QSEL_W(QSEL_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .qsel (qsel),
        .rsel (rsel)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_slot
        logic sel_me;
        assign sel_me = bus_we && hit && (qsel == QSEL_W'(g));

        qptr_slot #(.PTR_W(PTR_W), .INC_W(INC_W), .SZ_W(SZ_W), .DEF_LOG(DEF_LOG)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .add_rd   (sel_me && rsel == SEL_ADD_RD),
            .add_wr   (sel_me && rsel == SEL_ADD_WR),
            .size_wr  (sel_me && rsel == SEL_SIZE),
            .clr_wr   (sel_me && rsel == SEL_CLR),
            .inc      (bus_wdata[INC_W-1:0]),
            .size_in  (bus_wdata[SZ_W-1:0]),
            .clr_bit  (bus_wdata[0]),
            .rd_ptr   (rd_ptrs[g]),
            .wr_ptr   (wr_ptrs[g]),
            .size_log (sizes[g]),
            .ovf      (ovfs[g]),
            .udf      (udfs[g])
        );
    end

    qptr_rdmux #(.NUM_Q(NUM_Q), .QSEL_W(QSEL_W), .PTR_W(PTR_W), .SZ_W(SZ_W)) u_mux (
        .hit     (hit),
        .qsel    (qsel),
        .rsel    (rsel),
        .rd_ptrs (rd_ptrs),
        .wr_ptrs (wr_ptrs),
        .sizes   (sizes),
        .ovfs    (ovfs),
        .udfs    (udfs),
        .word    (rd_word)
    );

    // Register read data; idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_re ? rd_word : '0;
        end
    end

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0)); // R10
    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !hit) |=> (bus_rdata == '0)); // R2

endmodule

// File: tb/qptr_ctrl_test.sv
// Directed bench for the queue pointer controller: one task per scenario.
module qptr_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    qptr_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [19:0] qa(input int q, input int off);
        return 20'h80000 + 20'(q) * 20'h800 + 20'(off);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [19:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [19:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [19:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(req, d, exp);
    endtask

    // R1: every queue reads its reset values.
    task automatic t_reset;
        for (int q = 0; q < 8; q++) begin
            rd_check("R1 rd ptr", qa(q, 'h08), 32'h0);
            rd_check("R1 wr ptr", qa(q, 'h0C), 32'h0);
            rd_check("R1 size",   qa(q, 'h10), 32'd8);
        end
    endtask

    // R3/R4: add writes, masking of data bits, zero increment.
    task automatic t_add;
        bus_wr(qa(1, 'h04), 32'd5);
        rd_check("R3 wr add 5", qa(1, 'h0C), 32'd5);
        bus_wr(qa(1, 'h04), 32'h3F);
        rd_check("R3 wr add max", qa(1, 'h0C), 32'h44);
        bus_wr(qa(1, 'h00), 32'd3);
        rd_check("R4 rd ptr word", qa(1, 'h08), 32'd3);
        bus_wr(qa(1, 'h04), 32'h40);
        rd_check("R3 zero inc", qa(1, 'h0C), 32'h44);
        bus_wr(qa(1, 'h04), 32'hFFFF_FFC1);
        rd_check("R3 upper bits ignored", qa(1, 'h0C), 32'h45);
    endtask

    // R5: wrap modulo an 8-entry queue.
    task automatic t_wrap;
        bus_wr(qa(2, 'h10), 32'd3);
        bus_wr(qa(2, 'h04), 32'd6);
        bus_wr(qa(2, 'h00), 32'd6);
        bus_wr(qa(2, 'h04), 32'd5);
        rd_check("R5 wr wrap", qa(2, 'h0C), 32'd3);
        rd_check("R5 rd no flags", qa(2, 'h08), 32'd6);
        bus_wr(qa(2, 'h00), 32'd5);
        rd_check("R5 rd wrap", qa(2, 'h08), 32'd3);
    endtask

    // R7/R8/R9: overflow, underflow, stickiness and clear on a 4-entry queue.
    task automatic t_flags;
        bus_wr(qa(3, 'h10), 32'd2);
        bus_wr(qa(3, 'h04), 32'd4);
        rd_check("R7 full no ovf", qa(3, 'h08), 32'h0);
        bus_wr(qa(3, 'h04), 32'd1);
        rd_check("R7 ovf set", qa(3, 'h08), 32'h8000_0000);
        rd_check("R7 ptr advanced", qa(3, 'h0C), 32'd1);
        bus_wr(qa(3, 'h14), 32'hFFFF_FFFE);
        rd_check("R9 clear bit0 zero", qa(3, 'h08), 32'h8000_0000);
        bus_wr(qa(3, 'h14), 32'd1);
        rd_check("R9 cleared", qa(3, 'h08), 32'h0);
        bus_wr(qa(3, 'h00), 32'd5);
        rd_check("R8 udf set", qa(3, 'h08), 32'h4000_0001);
        bus_wr(qa(3, 'h04), 32'd2);
        rd_check("R9 udf sticky", qa(3, 'h08), 32'h4000_0001);
        rd_check("R8 wr ptr", qa(3, 'h0C), 32'd3);
        bus_wr(qa(3, 'h00), 32'd2);
        rd_check("R8 no udf within fill", qa(3, 'h08), 32'h4000_0003);
        bus_wr(qa(3, 'h14), 32'd1);
        rd_check("R9 udf cleared", qa(3, 'h08), 32'h3);
    endtask

    // R6: size write resets pointers, clamps and reads back.
    task automatic t_size;
        bus_wr(qa(4, 'h04), 32'd10);
        bus_wr(qa(4, 'h00), 32'd2);
        rd_check("R6 pre wr", qa(4, 'h0C), 32'd10);
        bus_wr(qa(4, 'h10), 32'd5);
        rd_check("R6 rd zeroed", qa(4, 'h08), 32'd0);
        rd_check("R6 wr zeroed", qa(4, 'h0C), 32'd0);
        rd_check("R6 size rb", qa(4, 'h10), 32'd5);
        bus_wr(qa(4, 'h10), 32'h1F);
        rd_check("R6 clamp", qa(4, 'h10), 32'd18);
        bus_wr(qa(4, 'h10), 32'h25);
        rd_check("R6 low bits only", qa(4, 'h10), 32'd5);
    endtask

    // R2/R10/R11: unmapped space, write-only offsets, idle data, isolation.
    task automatic t_map;
        bus_wr(qa(8, 'h04), 32'd7);
        rd_check("R2 absent queue", qa(8, 'h0C), 32'h0);
        bus_wr(20'h00004, 32'd9);
        rd_check("R2 below region", 20'h00008, 32'h0);
        rd_check("R2 q0 untouched", qa(0, 'h0C), 32'h0);
        rd_check("R10 add offset reads 0", qa(1, 'h04), 32'h0);
        rd_check("R10 clear offset reads 0", qa(1, 'h14), 32'h0);
        rd_check("R10 undefined offset", qa(1, 'h18), 32'h0);
        rd_check("R11 q1 kept", qa(1, 'h0C), 32'h45);
        rd_check("R11 q5 wr", qa(5, 'h0C), 32'h0);
        rd_check("R11 q5 size", qa(5, 'h10), 32'd8);
        rd_check("R11 q2 size", qa(2, 'h10), 32'd3);
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_wrap();
        t_flags();
        t_size();
        t_map();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule